// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins a card-side bus to a backplane-side bus, with one storage path in each direction. Every path has an active-low clock enable, a latch enable that is transparent when high, a direction clock and an active-low output enable. Together these make the path transparent, clock-captured, latched or held.

The card-side outputs are three-state. They are modelled as a data vector plus an enable. The backplane-side outputs are open drain: the block only asks a line to be pulled low, and an external termination pulls released lines high. Several devices can therefore share the backplane as a wired-OR of low drivers.

All control and data inputs are sampled on a fast system clock. The direction clocks and latch enables are detected as edges between consecutive samples.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: The data path is W bits wide in each direction (default 18), and every bit position travels independently of the others.
- R2: While a direction's latch enable is high, that direction's output value equals its input data, whatever its clock enable and clock are doing.
- R3: With latch enable low and clock enable low, a 0-to-1 change of the direction clock between consecutive system-clock samples loads the input data into storage.
- R4: While clock enable is high and latch enable is low, direction-clock edges are ignored and storage holds its value.
- R5: When latch enable falls while clock enable is low, the input data present at the fall is latched and held, whether the direction clock is high or low.
- R6: When latch enable falls while clock enable is high, storage keeps the value it last took while transparent.
- R7: Output enable low drives that direction's outputs. Output enable high releases them: the card-side enable output goes low, and no backplane line is pulled low.
- R8: A driven backplane bit is pulled low exactly when its output value is 0. A value of 1 leaves the line released.
- R9: During and after reset, storage is all zeros and both directions are released.
- R10: When two devices share the backplane lines, each line reads as the AND of the values the enabled drivers present, and the receiving path sees that resolved level.
- R11: A direction clock held high makes no further captures. Only a fresh 0-to-1 change loads storage.
- R12: Outputs reflect inputs sampled one system-clock edge earlier. Storage loaded on a detected clock edge appears one edge after that detection.

Each data bit is carried in its own bit position: bit i of the input drives bit i of the output. No other encoding is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls and data |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_in | input | W | Card-side data into the card-to-backplane path |
| card_out | output | W | Card-side data value of the backplane-to-card path |
| card_oe | output | 1 | Card-side three-state enable, high when driving |
| bp_in | input | W | Resolved backplane line levels |
| bp_pull_low | output | W | One per line; high requests an open-drain pull to low |
| c2b_clken_n | input | 1 | Card-to-backplane clock enable, active low |
| c2b_le | input | 1 | Card-to-backplane latch enable, transparent high |
| c2b_clk | input | 1 | Card-to-backplane direction clock |
| c2b_oe_n | input | 1 | Card-to-backplane output enable, active low |
| b2c_clken_n | input | 1 | Backplane-to-card clock enable, active low |
| b2c_le | input | 1 | Backplane-to-card latch enable, transparent high |
| b2c_clk | input | 1 | Backplane-to-card direction clock |
| b2c_oe_n | input | 1 | Backplane-to-card output enable, active low |

## Verification
Directed sequences drive each direction through transparency, a latch-enable fall with the clock both high and low, a clock rise, a clock held high with data changing, an inhibited edge, and a fall with clock enable high. Those steps separate capture-on-edge from capture-on-level, and latching of the current data from keeping the last transparent value. A walking one over all bit positions exposes crossed or stuck bits. Random control and data mixes catch interactions the directed steps miss. A second device on the same lines shows whether the pulls resolve as a wired AND of levels and reach the receiving path.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;
  localparam int NDIR    = 2;
  localparam int DIR_C2B = 0;
  localparam int DIR_B2C = 1;

  typedef struct packed {
    logic clken_n;
    logic le;
    logic dclk;
    logic oe_n;
  } dir_ctl_t;

  localparam dir_ctl_t CTL_IDLE = '{clken_n: 1'b1, le: 1'b0, dclk: 1'b0, oe_n: 1'b1};
endpackage

// File: rtl/xcvr_ctl_sync.sv
module xcvr_ctl_sync
  import bidir_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctl_t     ctl_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] din_s,
  output logic         le_s,
  output logic         cen_n_s,
  output logic         oe_n_s,
  output logic         clk_rise,
  output logic         le_fall
);
  dir_ctl_t     cur_q;
  dir_ctl_t     prev_q;
  logic [W-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= CTL_IDLE;
      prev_q <= CTL_IDLE;
      din_q  <= '0;
    end else begin
      cur_q  <= ctl_i;
      prev_q <= cur_q;
      din_q  <= din_i;
    end
  end

  assign din_s    = din_q;
  assign le_s     = cur_q.le;
  assign cen_n_s  = cur_q.clken_n;
  assign oe_n_s   = cur_q.oe_n;
  assign clk_rise = cur_q.dclk & ~prev_q.dclk;
  assign le_fall  = prev_q.le & ~cur_q.le;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_s,
  input  logic         le_s,
  input  logic         cen_n_s,
  input  logic         clk_rise,
  input  logic         le_fall,
  output logic [W-1:0] st_q,
  output logic [W-1:0] val_o
);
  // Storage update: follows while transparent, loads on an enabled clock
  // rise or an enabled latch-enable fall, otherwise holds.
  function automatic logic [W-1:0] next_hold(
    input logic [W-1:0] old_v,
    input logic [W-1:0] din,
    input logic         le,
    input logic         cen_n,
    input logic         rise,
    input logic         fall
  );
    if (le)
      return din;
    if (!cen_n && (rise || fall))
      return din;
    return old_v;
  endfunction

  function automatic logic [W-1:0] path_value(
    input logic         le,
    input logic [W-1:0] din,
    input logic [W-1:0] held
  );
    return le ? din : held;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= '0;
    else
      st_q <= next_hold(st_q, din_s, le_s, cen_n_s, clk_rise, le_fall);
  end

  assign val_o = path_value(le_s, din_s, st_q);
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import bidir_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] card_in,
  output logic [W-1:0] card_out,
  output logic         card_oe,
  input  logic [W-1:0] bp_in,
  output logic [W-1:0] bp_pull_low,
  input  logic         c2b_clken_n,
  input  logic         c2b_le,
  input  logic         c2b_clk,
  input  logic         c2b_oe_n,
  input  logic         b2c_clken_n,
  input  logic         b2c_le,
  input  logic         b2c_clk,
  input  logic         b2c_oe_n
);
  function automatic logic [W-1:0] od_drive(input logic en, input logic [W-1:0] v);
    return en ? ~v : '0;
  endfunction

  dir_ctl_t [NDIR-1:0]         dir_ctl;
  logic     [NDIR-1:0][W-1:0]  dir_raw;
  logic     [NDIR-1:0][W-1:0]  dir_din_s;
  logic     [NDIR-1:0][W-1:0]  dir_st;
  logic     [NDIR-1:0][W-1:0]  dir_val;
  logic     [NDIR-1:0]         dir_le_s;
  logic     [NDIR-1:0]         dir_cen_n_s;
  logic     [NDIR-1:0]         dir_oe_n_s;
  logic     [NDIR-1:0]         dir_rise;
  logic     [NDIR-1:0]         dir_lefall;
  logic     [NDIR-1:0]         dir_oe;

  assign dir_ctl[DIR_C2B] = '{clken_n: c2b_clken_n, le: c2b_le, dclk: c2b_clk, oe_n: c2b_oe_n};
  assign dir_ctl[DIR_B2C] = '{clken_n: b2c_clken_n, le: b2c_le, dclk: b2c_clk, oe_n: b2c_oe_n};
  assign dir_raw[DIR_C2B] = card_in;
  assign dir_raw[DIR_B2C] = bp_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_ctl_sync #(.W(W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_i    (dir_ctl[d]),
      .din_i    (dir_raw[d]),
      .din_s    (dir_din_s[d]),
      .le_s     (dir_le_s[d]),
      .cen_n_s  (dir_cen_n_s[d]),
      .oe_n_s   (dir_oe_n_s[d]),
      .clk_rise (dir_rise[d]),
      .le_fall  (dir_lefall[d])
    );

    xcvr_store #(.W(W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .din_s    (dir_din_s[d]),
      .le_s     (dir_le_s[d]),
      .cen_n_s  (dir_cen_n_s[d]),
      .clk_rise (dir_rise[d]),
      .le_fall  (dir_lefall[d]),
      .st_q     (dir_st[d]),
      .val_o    (dir_val[d])
    );

    assign dir_oe[d] = ~dir_oe_n_s[d];
  end

  assign bp_pull_low = od_drive(dir_oe[DIR_C2B], dir_val[DIR_C2B]);
  assign card_out    = dir_val[DIR_B2C];
  assign card_oe     = dir_oe[DIR_B2C];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk
  import bidir_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [W-1:0]            card_in,
  input logic [W-1:0]            card_out,
  input logic                    card_oe,
  input logic [W-1:0]            bp_in,
  input logic [W-1:0]            bp_pull_low,
  input logic                    c2b_le,
  input logic                    c2b_oe_n,
  input logic                    b2c_le,
  input logic                    b2c_oe_n,
  input logic [NDIR-1:0][W-1:0]  din_s,
  input logic [NDIR-1:0][W-1:0]  st,
  input logic [NDIR-1:0]         le_s,
  input logic [NDIR-1:0]         cen_n_s,
  input logic [NDIR-1:0]         rise,
  input logic [NDIR-1:0]         lefall
);
  // R2
  transp_c2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(c2b_le) && !$past(c2b_oe_n) |-> bp_pull_low == ~$past(card_in));

  // R2
  transp_b2c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(b2c_le) |-> card_out == $past(bp_in));

  // R7
  release_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(c2b_oe_n) |-> bp_pull_low == '0);

  // R7
  release_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> card_oe == !$past(b2c_oe_n));

  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[d] && !cen_n_s[d] && !le_s[d] |=> st[d] == $past(din_s[d]));

    // R4
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n_s[d] && !le_s[d] |=> $stable(st[d]));

    // R5
    latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lefall[d] && !cen_n_s[d] |=> st[d] == $past(din_s[d]));

    // R6
    keep_transp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lefall[d] && cen_n_s[d] |=> $stable(st[d]));

    // R11
    no_level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise[d] && !lefall[d] && !le_s[d] |=> $stable(st[d]));
  end
endmodule

bind bidir_reg_xcvr xcvr_chk #(.W(W)) u_xcvr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .card_in     (card_in),
  .card_out    (card_out),
  .card_oe     (card_oe),
  .bp_in       (bp_in),
  .bp_pull_low (bp_pull_low),
  .c2b_le      (c2b_le),
  .c2b_oe_n    (c2b_oe_n),
  .b2c_le      (b2c_le),
  .b2c_oe_n    (b2c_oe_n),
  .din_s       (dir_din_s),
  .st          (dir_st),
  .le_s        (dir_le_s),
  .cen_n_s     (dir_cen_n_s),
  .rise        (dir_rise),
  .lefall      (dir_lefall)
);

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] card_in = '0, peer_card_in = '0, ext_pull = '0;
  logic [W-1:0] card_out, peer_card_out, dut_pull, peer_pull, bp_line;
  logic card_oe, peer_card_oe;
  logic [1:0] cen_n = 2'b11, le = 2'b00, dck = 2'b00, oe_n = 2'b11;
  logic p_cen_n = 1'b1, p_le = 1'b0, p_dck = 1'b0, p_oe_n = 1'b1;

  assign bp_line = ~(dut_pull | peer_pull | ext_pull);

  bidir_reg_xcvr #(.W(W)) i_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n), .card_in(card_in), .card_out(card_out), .card_oe(card_oe),
    .bp_in(bp_line), .bp_pull_low(dut_pull),
    .c2b_clken_n(cen_n[0]), .c2b_le(le[0]), .c2b_clk(dck[0]), .c2b_oe_n(oe_n[0]),
    .b2c_clken_n(cen_n[1]), .b2c_le(le[1]), .b2c_clk(dck[1]), .b2c_oe_n(oe_n[1])
  );

  bidir_reg_xcvr #(.W(W)) i_peer (
    .clk(clk), .rst_n(rst_n), .card_in(peer_card_in), .card_out(peer_card_out),
    .card_oe(peer_card_oe), .bp_in(bp_line), .bp_pull_low(peer_pull),
    .c2b_clken_n(p_cen_n), .c2b_le(p_le), .c2b_clk(p_dck), .c2b_oe_n(p_oe_n),
    .b2c_clken_n(1'b1), .b2c_le(1'b0), .b2c_clk(1'b0), .b2c_oe_n(1'b1)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] m_st [2];
  logic m_le_prev [2];
  logic m_ck_prev [2];

  function automatic logic [W-1:0] model_store(input logic [W-1:0] old_v, input logic [W-1:0] din,
      input logic l, input logic l_prev, input logic cn, input logic ck, input logic ck_prev);
    if (l) return din;
    if (!cn && (l_prev || (ck && !ck_prev))) return din;
    return old_v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one steady step to direction d and check its outputs after settling.
  task automatic step(input int d, input logic cn, input logic l, input logic ck,
                      input logic on, input logic [W-1:0] data, input string tag);
    logic [W-1:0] val;
    @(negedge clk);
    cen_n[d] = cn; le[d] = l; dck[d] = ck; oe_n[d] = on;
    if (d == 0) card_in = data; else ext_pull = ~data;
    repeat (3) @(negedge clk);
    m_st[d] = model_store(m_st[d], data, l, m_le_prev[d], cn, ck, m_ck_prev[d]);
    m_le_prev[d] = l; m_ck_prev[d] = ck;
    val = l ? data : m_st[d];
    if (d == 0) begin
      check(tag, dut_pull, on ? '0 : ~val);
    end else begin
      check({tag, " oe"}, {{(W-1){1'b0}}, card_oe}, {{(W-1){1'b0}}, ~on});
      if (!on) check(tag, card_out, val);
    end
  endtask

  task automatic run_modes(input int d);
    step(d, 1, 1, 0, 0, 18'h2A5A5, "R2");
    step(d, 1, 1, 1, 0, 18'h15A5A, "R2");
    step(d, 0, 0, 1, 0, 18'h3C3C3, "R5");
    step(d, 0, 0, 1, 0, 18'h00FF0, "R5");
    step(d, 0, 1, 0, 0, 18'h11111, "R2");
    step(d, 0, 0, 0, 0, 18'h22222, "R5");
    step(d, 0, 0, 0, 0, 18'h0ABCD, "R5");
    step(d, 0, 0, 1, 0, 18'h0ABCD, "R3");
    step(d, 0, 0, 1, 0, 18'h35555, "R11");
    step(d, 0, 0, 0, 0, 18'h1F00F, "R3");
    step(d, 0, 0, 1, 0, 18'h1F00F, "R3");
    step(d, 1, 0, 0, 0, 18'h3FFFF, "R4");
    step(d, 1, 0, 1, 0, 18'h3FFFF, "R4");
    step(d, 1, 1, 0, 0, 18'h12345, "R6");
    step(d, 1, 0, 0, 0, 18'h2BCDE, "R6");
    step(d, 1, 0, 0, 1, 18'h2BCDE, "R7");
    step(d, 1, 0, 0, 0, 18'h2BCDE, "R7");
    step(d, 0, 0, 0, 0, 18'h00000, "R8");
    step(d, 0, 0, 1, 0, 18'h00000, "R8");
    for (int i = 0; i < W; i++) step(d, 1, 1, 0, 0, 18'(1) << i, "R1");
    for (int i = 0; i < 250; i++)
      step(d, 1'($urandom), ($urandom % 4) == 0, 1'($urandom), ($urandom % 5) == 0,
           W'($urandom), "R3");
    step(d, 1, 0, 0, 1, '0, "R7");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("watchdog expired at %0t", $time);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 2; d++) begin
      m_st[d] = '0; m_le_prev[d] = 0; m_ck_prev[d] = 0;
    end
    repeat (3) @(negedge clk);
    check("R9 reset pull", dut_pull, '0);
    check("R9 reset oe", {{(W-1){1'b0}}, card_oe}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 released pull", dut_pull, '0);
    // R9: storage zero seen through an enabled hold path
    step(0, 1, 0, 0, 0, 18'h3FFFF, "R9");
    step(1, 1, 0, 0, 0, 18'h3FFFF, "R9");
    step(1, 1, 0, 0, 1, 18'h3FFFF, "R7");
    step(0, 1, 0, 0, 1, 18'h00000, "R7");

    run_modes(0);
    run_modes(1);

    // R10: wired resolution with a peer device on the same lines
    @(negedge clk);
    cen_n[0] = 1; le[0] = 1; oe_n[0] = 0; card_in = 18'h3F0F0;
    p_cen_n = 1; p_le = 1; p_oe_n = 0; peer_card_in = 18'h0FF33;
    ext_pull = '0;
    cen_n[1] = 1; le[1] = 1; oe_n[1] = 0;
    repeat (5) @(negedge clk);
    check("R10 line", bp_line, 18'h3F0F0 & 18'h0FF33);
    check("R10 receive", card_out, 18'h3F0F0 & 18'h0FF33);
    @(negedge clk);
    p_oe_n = 1;
    repeat (5) @(negedge clk);
    check("R10 peer released", bp_line, 18'h3F0F0);
    check("R10 receive", card_out, 18'h3F0F0);
    // R12: one sampling edge of latency on the transparent path
    @(negedge clk);
    card_in = 18'h00001;
    check("R12 before edge", dut_pull, ~18'h3F0F0);
    @(negedge clk);
    check("R12 after edge", dut_pull, ~18'h00001);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule